// File: doc/BRIEF.md
# Terminal-Count Interrupt Timer Channel

This block is a single down-counting channel of an interval timer, fixed in the mode that raises an output when a programmed count runs out. Software selects a write format with a control strobe, then writes a count one byte at a time through an 8-bit port. On the next pulse of the counter clock the count moves into the counting element, and that pulse does not decrement it. Each later pulse that arrives while the gate input is high takes one off the count. The output line `out_line` stays low from the control write until the count reaches zero, then goes high and stays high.

The counter clock `tclk` is slow and unrelated to the system clock. It is resynchronised and edge-detected inside the block. A counter pulse is a rising edge followed by a falling edge. The gate level is captured at the rising edge, and the count changes at the falling edge. In the two-byte format, writing the low byte stops counting at once and drops the output. Writing the high byte then arms a reload, so software can restart the sequence at a time it chooses.

Top module: `tct_channel`

## Requirements
- R1: After reset, `out_line` is 0 and `null_count` is 0.
- R2: A control write (`ctrl_wr`) forces `out_line` low by the next system clock. No count is decremented and `out_line` stays low until a new count has been written and loaded.
- R3: The first counter pulse after a count is written loads it without a decrement. With count N (1..65535) and the gate high, `out_line` is still low after N pulses and goes high on pulse N+1.
- R4: A pulse whose captured gate is 0 does not decrement the count. Changes of the gate level never change `out_line`.
- R5: In the two-byte format, writing the first byte (the low byte) drives `out_line` low by the next system clock, and counting stops until the second byte is written.
- R6: Writing the second byte (the high byte) arms the assembled 16-bit value. It loads on the next pulse, and `out_line` rises N+1 pulses after that write.
- R7: Format field `fmt` is captured on `ctrl_wr`. 2'b01 selects a single low byte (count = byte). 2'b10 selects a single high byte (count = byte*256). 2'b11 and 2'b00 select low byte then high byte.
- R8: Once high, `out_line` stays high while the counter wraps through 0xFFFF and keeps counting. It stays high until a count is written or a control write occurs, and either of those drives it low.
- R9: `null_count` goes to 1 when a complete count has been written. It returns to 0 on the pulse that loads that count.
- R10: A count of 0 behaves as 65536, so `out_line` stays low for at least 300 gated pulses after loading it.
- R11: The decrement and the rise of `out_line` happen only at the falling edge of `tclk`. During the high phase of the terminal pulse, `out_line` is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tclk | input | 1 | Counter clock, sampled by `clk` |
| gate | input | 1 | Count enable, captured at each `tclk` rising edge |
| ctrl_wr | input | 1 | One-cycle strobe: control word for this mode written |
| fmt | input | 2 | Byte format, captured with `ctrl_wr` |
| data_wr | input | 1 | One-cycle strobe: a count byte is on `data_in` |
| data_in | input | 8 | Count byte |
| out_line | output | 1 | Terminal-count output |
| null_count | output | 1 | High while a written count waits to be loaded |

## Verification
The hardest situation to reach is a first-byte write that lands in the middle of an active count. The counting element then holds part of the old value, counting must freeze, and the reload must come from the newly assembled value, not from the remainder. Directed sequences load a count, run a few pulses, and write the low byte. They then run more pulses than the old remainder needed, write the high byte, and time the rise against the new value. Randomised runs mix formats, counts and gate-low pulses, and a bench model of the pulse count checks the output after every pulse.

// File: rtl/tct_pkg.sv
package tct_pkg;
  typedef enum logic [1:0] {
    FMT_PAIR0   = 2'b00,
    FMT_LO_ONLY = 2'b01,
    FMT_HI_ONLY = 2'b10,
    FMT_PAIR    = 2'b11
  } fmt_e;

  function automatic logic is_pair(input logic [1:0] f);
    return (f == FMT_PAIR) || (f == FMT_PAIR0);
  endfunction
endpackage

// File: rtl/tct_edge_sync.sv
module tct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tclk,
  input  logic gate,
  output logic rise_evt,
  output logic pulse_evt,
  output logic gate_en
);
  logic [STAGES-1:0] tq;
  logic [STAGES-1:0] gq;
  logic tprev;
  logic seen_rise;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tq[i] <= 1'b0;
          gq[i] <= 1'b0;
        end else if (i == 0) begin
          tq[i] <= tclk;
          gq[i] <= gate;
        end else begin
          tq[i] <= tq[i-1];
          gq[i] <= gq[i-1];
        end
      end
    end
  endgenerate

  assign rise_evt  = tq[STAGES-1] & ~tprev;
  assign pulse_evt = ~tq[STAGES-1] & tprev & seen_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tprev     <= 1'b0;
      seen_rise <= 1'b0;
      gate_en   <= 1'b0;
    end else begin
      tprev <= tq[STAGES-1];
      if (rise_evt) begin
        seen_rise <= 1'b1;
        gate_en   <= gq[STAGES-1];
      end else if (pulse_evt) begin
        seen_rise <= 1'b0;
      end
    end
  end

  // R11
  pulse_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !pulse_evt);
endmodule

// File: rtl/tct_count_reg.sv
module tct_count_reg #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_wr,
  input  logic [1:0]      fmt_in,
  input  logic            data_wr,
  input  logic [BW-1:0]   data_in,
  input  logic            load_ack,
  output logic [2*BW-1:0] cr,
  output logic            load_pend,
  output logic            null_cnt,
  output logic            halt,
  output logic            first_byte_evt,
  output logic            count_done_evt
);
  import tct_pkg::*;
  localparam int CW = 2 * BW;

  logic [1:0]    fmt_q;
  logic          hi_next;
  logic [BW-1:0] lo_hold;

  function automatic logic [CW-1:0] place_byte(input logic [1:0] f,
                                               input logic [BW-1:0] lo,
                                               input logic [BW-1:0] d);
    case (f)
      FMT_LO_ONLY: return {{BW{1'b0}}, d};
      FMT_HI_ONLY: return {d, {BW{1'b0}}};
      default:     return {d, lo};
    endcase
  endfunction

  assign first_byte_evt = data_wr & ~ctrl_wr & is_pair(fmt_q) & ~hi_next;
  assign count_done_evt = data_wr & ~ctrl_wr & ~first_byte_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q     <= FMT_PAIR;
      hi_next   <= 1'b0;
      lo_hold   <= '0;
      cr        <= '0;
      load_pend <= 1'b0;
      null_cnt  <= 1'b0;
      halt      <= 1'b0;
    end else if (ctrl_wr) begin
      fmt_q     <= fmt_in;
      hi_next   <= 1'b0;
      load_pend <= 1'b0;
      halt      <= 1'b0;
    end else if (first_byte_evt) begin
      lo_hold   <= data_in;
      hi_next   <= 1'b1;
      halt      <= 1'b1;
      load_pend <= 1'b0;
    end else if (count_done_evt) begin
      cr        <= place_byte(fmt_q, lo_hold, data_in);
      hi_next   <= 1'b0;
      halt      <= 1'b0;
      load_pend <= 1'b1;
      null_cnt  <= 1'b1;
    end else if (load_ack) begin
      load_pend <= 1'b0;
      null_cnt  <= 1'b0;
    end
  end

  // R9
  null_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_done_evt |=> null_cnt && load_pend);
  // R9
  null_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ack && !data_wr && !ctrl_wr) |=> !null_cnt);
  // R5
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_byte_evt |=> halt && !load_pend);
endmodule

// File: rtl/tct_count_elem.sv
module tct_count_elem #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse_evt,
  input  logic          gate_en,
  input  logic          load_pend,
  input  logic          halt,
  input  logic          stop,
  input  logic [CW-1:0] cr,
  output logic          load_ack,
  output logic          dec_evt,
  output logic          term_evt
);
  logic [CW-1:0] ce;
  logic          running;

  function automatic logic [CW-1:0] ce_step(input logic [CW-1:0] v);
    return v - 1'b1;
  endfunction

  function automatic logic ce_at_last(input logic [CW-1:0] v);
    return v == {{(CW-1){1'b0}}, 1'b1};
  endfunction

  assign load_ack = pulse_evt & load_pend;
  assign dec_evt  = pulse_evt & ~load_pend & running & gate_en & ~halt & ~stop;
  assign term_evt = dec_evt & ce_at_last(ce);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce      <= '0;
      running <= 1'b0;
    end else if (stop) begin
      running <= 1'b0;
    end else if (load_ack) begin
      ce      <= cr;
      running <= 1'b1;
    end else if (dec_evt) begin
      ce      <= ce_step(ce);
    end
  end

  // R3
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ack && !stop) |=> ce == $past(cr));
  // R4
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_evt && !load_pend && !gate_en) |=> $stable(ce));
  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_evt && ce == '0) |=> ce == {CW{1'b1}});
endmodule

// File: rtl/tct_channel.sv
module tct_channel #(
  parameter int BW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tclk,
  input  logic          gate,
  input  logic          ctrl_wr,
  input  logic [1:0]    fmt,
  input  logic          data_wr,
  input  logic [BW-1:0] data_in,
  output logic          out_line,
  output logic          null_count
);
  localparam int CW = 2 * BW;

  logic          rise_evt;
  logic          pulse_evt;
  logic          gate_en;
  logic [CW-1:0] cr;
  logic          load_pend;
  logic          halt;
  logic          first_byte_evt;
  logic          count_done_evt;
  logic          load_ack;
  logic          dec_evt;
  logic          term_evt;
  logic          drop_evt;
  logic          out_q;

  tct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .tclk     (tclk),
    .gate     (gate),
    .rise_evt (rise_evt),
    .pulse_evt(pulse_evt),
    .gate_en  (gate_en)
  );

  tct_count_reg #(.BW(BW)) u_creg (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_wr       (ctrl_wr),
    .fmt_in        (fmt),
    .data_wr       (data_wr),
    .data_in       (data_in),
    .load_ack      (load_ack),
    .cr            (cr),
    .load_pend     (load_pend),
    .null_cnt      (null_count),
    .halt          (halt),
    .first_byte_evt(first_byte_evt),
    .count_done_evt(count_done_evt)
  );

  tct_count_elem #(.CW(CW)) u_elem (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse_evt(pulse_evt),
    .gate_en  (gate_en),
    .load_pend(load_pend),
    .halt     (halt),
    .stop     (ctrl_wr),
    .cr       (cr),
    .load_ack (load_ack),
    .dec_evt  (dec_evt),
    .term_evt (term_evt)
  );

  assign drop_evt = ctrl_wr | first_byte_evt | count_done_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_q <= 1'b0;
    else if (drop_evt) out_q <= 1'b0;
    else if (term_evt) out_q <= 1'b1;
  end

  assign out_line = out_q;

  // R2
  ctrl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !out_line);
  // R5
  first_byte_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_byte_evt |=> !out_line);
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_line && !drop_evt) |=> out_line);
  // R11
  rise_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_line) |-> $past(pulse_evt));
endmodule

// File: tb/tct_channel_bench.sv
module tct_channel_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tclk = 1'b0;
  logic       gate = 1'b1;
  logic       ctrl_wr = 1'b0;
  logic [1:0] fmt = 2'b11;
  logic       data_wr = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic       out_line;
  logic       null_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tct_channel u_tct_channel (
    .clk(clk), .rst_n(rst_n), .tclk(tclk), .gate(gate),
    .ctrl_wr(ctrl_wr), .fmt(fmt), .data_wr(data_wr), .data_in(data_in),
    .out_line(out_line), .null_count(null_count)
  );

  function automatic int fire_pulse(input int n);
    return (n == 0) ? 65537 : n + 1;
  endfunction

  function automatic int count_of(input logic [1:0] f, input int lo, input int hi);
    if (f == 2'b01) return lo;
    if (f == 2'b10) return hi * 256;
    return hi * 256 + lo;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input logic g);
    @(negedge clk) gate = g;
    @(negedge clk) tclk = 1'b1;
    repeat (5) @(negedge clk);
    tclk = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) pulse(1'b1);
  endtask

  task automatic wr_ctrl(input logic [1:0] f);
    @(negedge clk) begin ctrl_wr = 1'b1; fmt = f; end
    @(negedge clk) ctrl_wr = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk) begin data_wr = 1'b1; data_in = b; end
    @(negedge clk) data_wr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out", out_line, 1'b0);
    chk("R1 null", null_count, 1'b0);

    // R2: control word without a count: nothing counts
    wr_ctrl(2'b11);
    chk("R2 out low", out_line, 1'b0);
    pulses(5);
    chk("R2 no count", out_line, 1'b0);

    // R3 and R9: count 3 in two-byte form
    wr_byte(8'd3);
    wr_byte(8'd0);
    chk("R9 null set", null_count, 1'b1);
    pulse(1'b1);
    chk("R9 null clr", null_count, 1'b0);
    pulses(2);
    chk("R3 low after N", out_line, 1'b0);
    pulse(1'b1);
    chk("R3 high at N+1", out_line, 1'b1);

    // R8: wrap keeps OUT high; gate changes do not move OUT (R4)
    pulses(10);
    chk("R8 hold", out_line, 1'b1);
    pulse(1'b0);
    @(negedge clk) gate = 1'b1;
    chk("R4 gate no effect", out_line, 1'b1);

    // R5: first byte drops OUT at once
    @(negedge clk) begin data_wr = 1'b1; data_in = 8'd2; end
    @(negedge clk) data_wr = 1'b0;
    chk("R5 immediate drop", out_line, 1'b0);
    wr_byte(8'd0);
    pulses(2);
    // R11: terminal pulse high phase
    @(negedge clk) gate = 1'b1;
    @(negedge clk) tclk = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 low in high phase", out_line, 1'b0);
    tclk = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 high after fall", out_line, 1'b1);

    // R8: new count drops OUT
    wr_ctrl(2'b01);
    wr_ctrl(2'b11);
    chk("R2 ctrl drop", out_line, 1'b0);
    wr_byte(8'd1);
    wr_byte(8'd0);
    pulses(2);
    chk("R3 count1", out_line, 1'b1);
    wr_byte(8'd9);
    chk("R8 count write drops", out_line, 1'b0);

    // R5/R6: freeze mid count, then reload
    wr_byte(8'd0);
    pulses(4);
    wr_byte(8'd5);
    pulses(12);
    chk("R5 halted", out_line, 1'b0);
    wr_byte(8'd0);
    pulses(5);
    chk("R6 low at N", out_line, 1'b0);
    pulse(1'b1);
    chk("R6 high at N+1", out_line, 1'b1);

    // R7: single low byte
    wr_ctrl(2'b01);
    wr_byte(8'd4);
    pulses(count_of(2'b01, 4, 0));
    chk("R7 lo low", out_line, 1'b0);
    pulse(1'b1);
    chk("R7 lo high", out_line, 1'b1);
    // R7: single high byte
    wr_ctrl(2'b10);
    wr_byte(8'd1);
    pulses(fire_pulse(count_of(2'b10, 0, 1)) - 1);
    chk("R7 hi low", out_line, 1'b0);
    pulse(1'b1);
    chk("R7 hi high", out_line, 1'b1);

    // R10: zero means 65536
    wr_ctrl(2'b00);
    wr_byte(8'd0);
    wr_byte(8'd0);
    pulses(300);
    chk("R10 zero count", out_line, 1'b0);

    // R4 with R3: random formats, counts and gate-low pulses
    for (int t = 0; t < 15; t++) begin
      logic [1:0] f;
      int n, rem, lo;
      bit loaded;
      f = ($urandom % 2) ? 2'b11 : 2'b01;
      lo = 1 + ($urandom % 40);
      wr_ctrl(f);
      wr_byte(lo[7:0]);
      if (f == 2'b11) wr_byte(8'd0);
      n = count_of(f, lo, 0);
      rem = n;
      loaded = 1'b0;
      for (int p = 0; p < n + 12; p++) begin
        logic g;
        g = (($urandom % 4) != 0);
        pulse(g);
        if (!loaded) loaded = 1'b1;
        else if (g && rem > 0) rem--;
        chk("R4 random gated count", out_line, (rem == 0));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule